// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws solid rectangles and moves rectangular areas inside a linear frame buffer held in byte-addressed memory. A command gives a destination corner, a width and height in pixels, and either a 32-bit colour (fill) or a source corner (copy). The pixel depth (1 to 4 bytes per pixel) and the screen width in pixels come from configuration inputs. The byte address of a pixel is the row pitch (bytes per pixel times screen width) times its row, plus bytes per pixel times its column.

Each operation works one byte at a time over a memory port that has one request in flight. A fill first writes the top row from the colour pattern, then copies that row into each row below it. A copy picks its row order and byte order so that overlapping source and destination areas come out as if moved in one step. When an operation ends, its destination rectangle goes into a ring of pending screen updates. A flush request either drains that ring in order, or empties it silently when the whole screen is known to need a redraw.

Top module: `rfe_engine`

## Requirements
- R1: After reset the engine is idle: cmd_busy, mem_req, cmd_done and dq_valid are all low.
- R2: The byte address of pixel (x, y) is bypp*x + bypp*scr_w*y, where bypp is cfg_bypp (1 to 4) and scr_w is cfg_scr_w.
- R3: A fill writes the top row byte by byte in ascending address order. The byte written at offset j of the row is colour byte (j mod bypp), where byte 0 is bits 7:0.
- R4: After its top row, a fill handles each following row i (1 to h-1) in ascending byte order. For each byte it reads the byte at the same offset in the top row, then writes that value to row y+i.
- R5: A copy whose destination y is greater than its source y handles rows from the last one (offset h-1) up to offset 0.
- R6: Any other copy handles rows from offset 0 downward. Within a row it runs in ascending byte order unless R7 applies.
- R7: A copy with equal source and destination y and destination x greater than source x runs each row from the highest byte offset to the lowest.
- R8: Each copied byte is a read of the source byte followed by a write of that value to the destination byte. The memory contents after a copy match an overlap-safe move.
- R9: A command with zero width or zero height makes no memory access. Its cmd_done pulse appears one cycle after the start is accepted.
- R10: A request holds mem_addr, mem_we and mem_wdata steady until it is acknowledged. cmd_done is a single-cycle pulse that comes after the last acknowledged access.
- R11: cmd_start has no effect while cmd_busy is high.
- R12: Every finished command, including a zero-size one, adds its destination rectangle (x, y, w, h) to a ring of DEPTH entries whose indices wrap. A flush without invalidate outputs the entries oldest first, one per cycle, with dq_valid high.
- R13: A flush with flush_inval high empties the ring and outputs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_scr_w | input | CW | Screen width in pixels |
| cmd_start | input | 1 | Start a command when idle |
| cmd_copy | input | 1 | 1 = copy, 0 = fill |
| cmd_x | input | CW | Destination x |
| cmd_y | input | CW | Destination y |
| cmd_w | input | CW | Width in pixels |
| cmd_h | input | CW | Height in pixels |
| cmd_sx | input | CW | Source x (copy) |
| cmd_sy | input | CW | Source y (copy) |
| cmd_color | input | 32 | Fill colour |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Request accepted/completed |
| flush_req | input | 1 | Flush the update ring |
| flush_inval | input | 1 | With flush_req: discard instead of drain |
| dq_valid | output | 1 | Drained rectangle valid |
| dq_x | output | CW | Drained rectangle x |
| dq_y | output | CW | Drained rectangle y |
| dq_w | output | CW | Drained rectangle width |
| dq_h | output | CW | Drained rectangle height |

## Verification
Fills run at every pixel depth from one to four bytes with a colour whose bytes all differ. This exposes a wrong byte order or a wrong point of wrap in the pattern, and single-row and multi-row fills separate the pattern phase from the row-replication phase. Copies cover four cases: a non-overlapping upward move, an overlapping downward move, and same-row moves to the right and to the left. Each one fixes a distinct row and byte order. Since the memory model returns the live contents, a wrong order shows up both as a wrong access sequence and as corrupted data. Zero-size commands, a start pulse issued mid-operation, and draining versus discarding the update ring check the control edges.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD,
    ST_WR,
    ST_PUSH
  } rfe_st_e;

  // Select colour byte k, least significant byte first.
  function automatic logic [7:0] rfe_col_byte(input logic [31:0] col, input logic [1:0] k);
    logic [7:0] b;
    case (k)
      2'd0:    b = col[7:0];
      2'd1:    b = col[15:8];
      2'd2:    b = col[23:16];
      default: b = col[31:24];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rfe_colrot.sv
module rfe_colrot
  import rfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        step,
  input  logic [2:0]  bypp,
  input  logic [31:0] color,
  output logic [7:0]  byte_o
);

  logic [1:0] k_q;
  logic       wrap;

  assign wrap   = ({1'b0, k_q} == (bypp - 3'd1));
  assign byte_o = rfe_col_byte(color, k_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       k_q <= '0;
    else if (restart) k_q <= '0;
    else if (step)    k_q <= wrap ? 2'd0 : k_q + 2'd1;
  end

endmodule

// File: rtl/rfe_seq.sv
module rfe_seq
  import rfe_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          copy_i,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [31:0]   color,
  input  logic [2:0]    bypp,
  input  logic [CW-1:0] scr_w,
  output logic          busy,
  output logic          done,
  output logic          push,
  output logic [4*CW-1:0] push_rect,
  output logic [31:0]   lcol,
  output logic          cr_restart,
  output logic          cr_step,
  input  logic [7:0]    cr_byte,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);

  localparam int RBW = CW + 3;

  function automatic logic [AW-1:0] pix_addr(input logic [CW-1:0] px, input logic [CW-1:0] py,
                                             input logic [2:0] bpp, input logic [CW-1:0] sw);
    logic [AW-1:0] lin;
    lin = AW'(px) + AW'(sw) * AW'(py);
    return AW'(bpp) * lin;
  endfunction

  rfe_st_e        st;
  logic           is_fill, up, desc;
  logic [CW-1:0]  lx, ly, lw, lh, lsx, lsy, i_q;
  logic [RBW-1:0] rb, j_q;
  logic [7:0]     hold;

  logic [CW-1:0]  row_off, src_y, dst_y;
  logic [RBW-1:0] boff;
  logic [AW-1:0]  src_a, dst_a;
  logic           last_byte;

  assign row_off   = up ? (lh - CW'(1) - i_q) : i_q;
  assign src_y     = is_fill ? lsy : lsy + row_off;
  assign dst_y     = is_fill ? ly + i_q : ly + row_off;
  assign boff      = desc ? (rb - RBW'(1) - j_q) : j_q;
  assign src_a     = pix_addr(lsx, src_y, bypp, scr_w) + AW'(boff);
  assign dst_a     = pix_addr(lx, dst_y, bypp, scr_w) + AW'(boff);
  assign last_byte = (j_q == rb - RBW'(1));

  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_PUSH);
  assign push       = (st == ST_PUSH);
  assign push_rect  = {lx, ly, lw, lh};
  assign cr_restart = (st == ST_IDLE) && start;
  assign cr_step    = (st == ST_FILL) && mem_ack;
  assign mem_req    = (st == ST_FILL) || (st == ST_RD) || (st == ST_WR);
  assign mem_we     = (st != ST_RD);
  assign mem_addr   = (st == ST_RD) ? src_a : dst_a;
  assign mem_wdata  = (st == ST_FILL) ? cr_byte : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      is_fill <= 1'b0; up <= 1'b0; desc <= 1'b0;
      lx <= '0; ly <= '0; lw <= '0; lh <= '0; lsx <= '0; lsy <= '0;
      i_q <= '0; j_q <= '0; rb <= '0; hold <= '0; lcol <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          is_fill <= !copy_i;
          lx <= x; ly <= y; lw <= w; lh <= h;
          lsx <= copy_i ? sx : x;
          lsy <= copy_i ? sy : y;
          lcol <= color;
          rb <= RBW'(bypp) * RBW'(w);
          up <= copy_i && (y > sy);
          desc <= copy_i && (y == sy) && (x > sx);
          i_q <= '0;
          j_q <= '0;
          if (w == '0 || h == '0) st <= ST_PUSH;
          else if (copy_i)        st <= ST_RD;
          else                    st <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          if (last_byte) begin
            j_q <= '0;
            if (lh == CW'(1)) st <= ST_PUSH;
            else begin
              i_q <= CW'(1);
              st  <= ST_RD;
            end
          end else begin
            j_q <= j_q + RBW'(1);
          end
        end
        ST_RD: if (mem_ack) begin
          hold <= mem_rdata;
          st   <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          st <= ST_RD;
          if (last_byte) begin
            j_q <= '0;
            if (i_q == lh - CW'(1)) st <= ST_PUSH;
            else i_q <= i_q + CW'(1);
          end else begin
            j_q <= j_q + RBW'(1);
          end
        end
        ST_PUSH: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rfe_dirtyq.sv
module rfe_dirtyq #(
  parameter int CW    = 12,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [4*CW-1:0] push_rect,
  input  logic          flush,
  input  logic          inval,
  output logic          out_valid,
  output logic [4*CW-1:0] out_rect
);

  localparam int PW = $clog2(DEPTH);
  localparam int RW = 4 * CW;

  logic [RW-1:0] q_mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic          draining;

  assign out_valid = draining && (head != tail);
  assign out_rect  = q_mem[head];

  always_ff @(posedge clk) begin
    if (push) q_mem[tail] <= push_rect;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      draining <= 1'b0;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (flush && inval) begin
        head     <= tail;
        draining <= 1'b0;
      end else begin
        if (flush) draining <= 1'b1;
        if (out_valid) head <= head + PW'(1);
        else if (draining && !flush) draining <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rfe_engine.sv
module rfe_engine #(
  parameter int CW    = 12,
  parameter int AW    = 20,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_bypp,
  input  logic [CW-1:0] cfg_scr_w,
  input  logic          cmd_start,
  input  logic          cmd_copy,
  input  logic [CW-1:0] cmd_x,
  input  logic [CW-1:0] cmd_y,
  input  logic [CW-1:0] cmd_w,
  input  logic [CW-1:0] cmd_h,
  input  logic [CW-1:0] cmd_sx,
  input  logic [CW-1:0] cmd_sy,
  input  logic [31:0]   cmd_color,
  output logic          cmd_busy,
  output logic          cmd_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  input  logic          flush_req,
  input  logic          flush_inval,
  output logic          dq_valid,
  output logic [CW-1:0] dq_x,
  output logic [CW-1:0] dq_y,
  output logic [CW-1:0] dq_w,
  output logic [CW-1:0] dq_h
);

  logic            push_evt;
  logic [4*CW-1:0] push_rect;
  logic [4*CW-1:0] out_rect;
  logic [31:0]     lcol;
  logic            cr_restart, cr_step;
  logic [7:0]      cr_byte;

  rfe_seq #(.CW(CW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .copy_i(cmd_copy),
    .x(cmd_x), .y(cmd_y), .w(cmd_w), .h(cmd_h), .sx(cmd_sx), .sy(cmd_sy),
    .color(cmd_color), .bypp(cfg_bypp), .scr_w(cfg_scr_w),
    .busy(cmd_busy), .done(cmd_done), .push(push_evt), .push_rect(push_rect),
    .lcol(lcol), .cr_restart(cr_restart), .cr_step(cr_step), .cr_byte(cr_byte),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  rfe_colrot u_col (
    .clk(clk), .rst_n(rst_n), .restart(cr_restart), .step(cr_step),
    .bypp(cfg_bypp), .color(lcol), .byte_o(cr_byte)
  );

  rfe_dirtyq #(.CW(CW), .DEPTH(DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_rect(push_rect),
    .flush(flush_req), .inval(flush_inval), .out_valid(dq_valid), .out_rect(out_rect)
  );

  assign {dq_x, dq_y, dq_w, dq_h} = out_rect;

endmodule

// File: rtl/rfe_engine_chk.sv
module rfe_engine_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_busy,
  input logic          cmd_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_ack,
  input logic          flush_req,
  input logic          flush_inval,
  input logic          dq_valid,
  input logic          cr_step
);

  // R10: a pending request stays unchanged until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |-> !mem_req);

  // R13: a discarding flush produces no output
  p_inval_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && flush_inval |=> !dq_valid);

  // R3: the colour pattern advances only on an acknowledged write
  p_colour_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cr_step |-> mem_we && mem_ack);

endmodule

bind rfe_engine rfe_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .flush_req(flush_req), .flush_inval(flush_inval),
  .dq_valid(dq_valid), .cr_step(cr_step)
);

// File: tb/rfe_engine_tb_top.sv
module rfe_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int AW = 20;
  localparam int SCR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_bypp = 3'd1;
  logic [CW-1:0] cfg_scr_w = CW'(SCR_W);
  logic cmd_start = 1'b0, cmd_copy = 1'b0;
  logic [CW-1:0] cmd_x = '0, cmd_y = '0, cmd_w = '0, cmd_h = '0, cmd_sx = '0, cmd_sy = '0;
  logic [31:0] cmd_color = '0;
  logic cmd_busy, cmd_done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic flush_req = 1'b0, flush_inval = 1'b0;
  logic dq_valid;
  logic [CW-1:0] dq_x, dq_y, dq_w, dq_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bypp(cfg_bypp), .cfg_scr_w(cfg_scr_w),
    .cmd_start(cmd_start), .cmd_copy(cmd_copy), .cmd_x(cmd_x), .cmd_y(cmd_y),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_color(cmd_color),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .flush_req(flush_req), .flush_inval(flush_inval), .dq_valid(dq_valid),
    .dq_x(dq_x), .dq_y(dq_y), .dq_w(dq_w), .dq_h(dq_h)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic          we;
    logic [7:0]    d;
    string         tag;
  } op_t;

  op_t exp_q[$];
  logic [4*CW-1:0] exp_r[$];
  logic [7:0] mem_m [0:4095];
  logic [7:0] ref_m [0:4095];
  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] lf = 8'hA5;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int ea(input int x, input int y, input int bpp);
    return bpp * x + bpp * SCR_W * y;
  endfunction

  task automatic push_op(input int a, input bit we, input logic [7:0] d, input string tag);
    op_t o;
    o.a = AW'(a); o.we = we; o.d = d; o.tag = tag;
    exp_q.push_back(o);
  endtask

  function automatic logic [4*CW-1:0] mk_rect(input int x, input int y, input int w, input int h);
    return {CW'(x), CW'(y), CW'(w), CW'(h)};
  endfunction

  task automatic gen_fill(input int x, input int y, input int w, input int h, input int bpp,
                          input logic [31:0] col, input string tag);
    int base;
    int rb;
    base = ea(x, y, bpp);
    rb = bpp * w;
    if (w != 0 && h != 0) begin
      for (int j = 0; j < rb; j++) begin
        logic [7:0] b;
        b = 8'(col >> (8 * (j % bpp)));
        push_op(base + j, 1'b1, b, tag);
        ref_m[base + j] = b;
      end
      for (int i = 1; i < h; i++) begin
        for (int j = 0; j < rb; j++) begin
          int s, d;
          s = base + j;
          d = ea(x, y + i, bpp) + j;
          push_op(s, 1'b0, 8'h00, tag);
          push_op(d, 1'b1, ref_m[s], tag);
          ref_m[d] = ref_m[s];
        end
      end
    end
    exp_r.push_back(mk_rect(x, y, w, h));
  endtask

  task automatic gen_copy(input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h, input int bpp, input string tag);
    int rb;
    rb = bpp * w;
    if (w != 0 && h != 0) begin
      for (int r = 0; r < h; r++) begin
        int row;
        row = (dy > sy) ? (h - 1 - r) : r;
        for (int jj = 0; jj < rb; jj++) begin
          int j, s, d;
          j = (dy == sy && dx > sx) ? (rb - 1 - jj) : jj;
          s = ea(sx, sy + row, bpp) + j;
          d = ea(dx, dy + row, bpp) + j;
          push_op(s, 1'b0, 8'h00, tag);
          push_op(d, 1'b1, ref_m[s], tag);
          ref_m[d] = ref_m[s];
        end
      end
    end
    exp_r.push_back(mk_rect(dx, dy, w, h));
  endtask

  task automatic drive_cmd(input bit cp, input int x, input int y, input int w, input int h,
                           input int sx, input int sy, input logic [31:0] col, input int bpp);
    cfg_bypp = 3'(bpp);
    cmd_copy = cp;
    cmd_x = CW'(x); cmd_y = CW'(y); cmd_w = CW'(w); cmd_h = CW'(h);
    cmd_sx = CW'(sx); cmd_sy = CW'(sy); cmd_color = col;
    cmd_start = 1'b1;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      cmd_start = 1'b0;
      cyc++;
      if (cmd_done) break;
    end
    // R10: every expected access has happened before the done pulse
    chk(exp_q.size() == 0, "R10", "accesses pending at done", exp_q.size(), 0);
  endtask

  task automatic run_cmd(input bit cp, input int x, input int y, input int w, input int h,
                         input int sx, input int sy, input logic [31:0] col, input int bpp,
                         output int cyc);
    @(negedge clk);
    while (cmd_busy) @(negedge clk);
    drive_cmd(cp, x, y, w, h, sx, sy, col, bpp);
    wait_done(cyc);
  endtask

  task automatic do_flush(input string tag);
    @(negedge clk);
    flush_req = 1'b1; flush_inval = 1'b0;
    @(negedge clk);
    flush_req = 1'b0;
    while (dq_valid) begin
      if (exp_r.size() == 0) chk(1'b0, tag, "extra drained rectangle", int'(dq_x), 0);
      else begin
        logic [4*CW-1:0] e;
        e = exp_r.pop_front();
        chk({dq_x, dq_y, dq_w, dq_h} == e, tag, "drained rectangle",
            int'({dq_x, dq_y}), int'(e[4*CW-1:2*CW]));
      end
      @(negedge clk);
    end
    chk(exp_r.size() == 0, tag, "rectangles left undrained", exp_r.size(), 0);
  endtask

  // Memory model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (!(lf[0] && lf[3])) begin
          if (exp_q.size() == 0)
            chk(1'b0, "R9", "unexpected memory access", int'(mem_addr), 0);
          else begin
            op_t e;
            e = exp_q.pop_front();
            chk(mem_addr == e.a && mem_we == e.we && (!e.we || mem_wdata == e.d), e.tag,
                "memory access", int'({mem_we, mem_addr, mem_wdata}), int'({e.we, e.a, e.d}));
          end
          if (mem_we) mem_m[mem_addr[11:0]] = mem_wdata;
          else mem_rdata = mem_m[mem_addr[11:0]];
          mem_ack = 1'b1;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int bad;
    for (int a = 0; a < 4096; a++) begin
      mem_m[a] = 8'(a * 7 + 3);
      ref_m[a] = 8'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!cmd_busy && !mem_req && !cmd_done && !dq_valid, "R1", "idle after reset",
        int'({cmd_busy, mem_req, cmd_done, dq_valid}), 0);

    // R2: single pixel address
    gen_fill(5, 3, 1, 1, 2, 32'h0000_1234, "R2");
    run_cmd(1'b0, 5, 3, 1, 1, 0, 0, 32'h0000_1234, 2, cyc);

    // R3: colour pattern wraps after bypp bytes (3 bytes per pixel)
    gen_fill(1, 1, 3, 1, 3, 32'hA1B2_C3D4, "R3");
    run_cmd(1'b0, 1, 1, 3, 1, 0, 0, 32'hA1B2_C3D4, 3, cyc);
    gen_fill(0, 7, 2, 1, 1, 32'h0000_00E7, "R3");
    run_cmd(1'b0, 0, 7, 2, 1, 0, 0, 32'h0000_00E7, 1, cyc);

    // R4: multi-row fills replicate the top row
    gen_fill(2, 4, 2, 3, 4, 32'h1122_3344, "R4");
    run_cmd(1'b0, 2, 4, 2, 3, 0, 0, 32'h1122_3344, 4, cyc);
    gen_fill(0, 0, 4, 2, 1, 32'h0000_0055, "R4");
    run_cmd(1'b0, 0, 0, 4, 2, 0, 0, 32'h0000_0055, 1, cyc);

    // R6: destination above source, top-down
    gen_copy(2, 5, 1, 2, 3, 2, 2, "R6");
    run_cmd(1'b1, 1, 2, 3, 2, 2, 5, 32'h0, 2, cyc);

    // R5: overlapping move downward, bottom-up
    gen_copy(3, 1, 4, 2, 4, 3, 1, "R5");
    run_cmd(1'b1, 4, 2, 4, 3, 3, 1, 32'h0, 1, cyc);

    // R7: same rows, moving right, bytes descending
    gen_copy(1, 6, 3, 6, 5, 2, 2, "R7");
    run_cmd(1'b1, 3, 6, 5, 2, 1, 6, 32'h0, 2, cyc);

    // R6: same row, moving left, bytes ascending
    gen_copy(4, 0, 2, 0, 5, 1, 3, "R6");
    run_cmd(1'b1, 2, 0, 5, 1, 4, 0, 32'h0, 3, cyc);

    // R9: zero width and zero height
    gen_fill(3, 3, 0, 4, 2, 32'hFFFF_FFFF, "R9");
    run_cmd(1'b0, 3, 3, 0, 4, 0, 0, 32'hFFFF_FFFF, 2, cyc);
    chk(cyc == 1, "R9", "zero-width done latency", cyc, 1);
    gen_copy(0, 0, 5, 5, 3, 0, 1, "R9");
    run_cmd(1'b1, 5, 5, 3, 0, 0, 0, 32'h0, 1, cyc);
    chk(cyc == 1, "R9", "zero-height done latency", cyc, 1);

    // R11: a start pulse during a busy copy is ignored
    gen_copy(0, 3, 8, 3, 4, 2, 1, "R11");
    @(negedge clk);
    while (cmd_busy) @(negedge clk);
    drive_cmd(1'b1, 8, 3, 4, 2, 0, 3, 32'h0, 1);
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(cmd_busy == 1'b1, "R11", "busy mid-copy", int'(cmd_busy), 1);
    drive_cmd(1'b0, 9, 0, 2, 2, 0, 0, 32'h5A5A_5A5A, 1);
    wait_done(cyc);
    repeat (10) @(negedge clk);
    chk(!cmd_busy && !cmd_done, "R11", "no second command after intrusion",
        int'({cmd_busy, cmd_done}), 0);

    // R12: drain the update ring in order
    do_flush("R12");

    // R13: discard, then a normal flush yields nothing
    gen_fill(6, 6, 1, 1, 1, 32'h0000_0011, "R13");
    run_cmd(1'b0, 6, 6, 1, 1, 0, 0, 32'h0000_0011, 1, cyc);
    gen_fill(7, 6, 1, 1, 1, 32'h0000_0022, "R13");
    run_cmd(1'b0, 7, 6, 1, 1, 0, 0, 32'h0000_0022, 1, cyc);
    @(negedge clk);
    flush_req = 1'b1; flush_inval = 1'b1;
    @(negedge clk);
    flush_req = 1'b0; flush_inval = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!dq_valid, "R13", "output during discard", int'(dq_valid), 0);
      @(negedge clk);
    end
    exp_r.delete();
    do_flush("R13");

    // R8: memory matches an overlap-safe reference
    bad = 0;
    for (int a = 0; a < 1024; a++) if (mem_m[a] !== ref_m[a]) bad++;
    chk(bad == 0, "R8", "memory bytes differing from reference", bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule